// File: doc/BRIEF.md
# Bit-Serial Successive Approximation Conversion Sequencer

This block runs a binary search that turns an analog level into an N-bit code. It uses an external resistor-ladder DAC and a single comparator. A start pulse raises the hold line, which freezes the sampled input. The block then places a trial code on the DAC with only the top bit set, which is half of full scale. After a set settling time it reads the comparator.

A trial bit stays set when the comparator reports that the input is at or above the ladder level. It is cleared when the ladder level is above the input. The bits already decided are kept while the next lower bit is tried. One bit is resolved per step until the least significant bit is settled. Then the final code is stored in the result register, a one-cycle done strobe is issued and the hold line is released.

The comparator output is brought in through a two-flop synchronizer. The synchronizer delay is part of the settling count, so `SETTLE_CLKS` must be at least 2. Each bit step lasts `SETTLE_CLKS + 1` clocks, so a full conversion takes `WIDTH * (SETTLE_CLKS + 1)` clocks.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is asserted and after it is released with no start, `dac_code_o` is 0, `hold_o` is 0, `done_o` is 0 and `result_o` is 0.
- R2: A start pulse seen in idle makes, after that clock edge, `hold_o` = 1 and `dac_code_o` equal to a code with only bit WIDTH-1 set.
- R3: The comparator input `cmp_i` = 1 means the input is at or above the DAC level, and the trial bit is kept. `cmp_i` = 0 clears the trial bit. Bits already decided never change during the search. With defaults, the result equals the input level for levels 0..255 and equals 255 above that.
- R4: Bits are tried from bit WIDTH-1 down to bit 0. During one conversion the DAC code changes exactly WIDTH-1 times, once per bit step of `SETTLE_CLKS + 1` clocks.
- R5: `done_o` is high after clock edge number `WIDTH*(SETTLE_CLKS+1)`, counted from the edge that accepted the start (24 with defaults).
- R6: `hold_o` stays at 1 from the first trial until the cycle in which `done_o` rises. In that cycle it is 0.
- R7: `done_o` is a single-cycle pulse. `result_o` changes only in a cycle in which `done_o` is high and holds its value until the next conversion ends.
- R8: A start pulse that arrives while a conversion is running has no effect on its result or its timing.
- R9: Asserting reset in the middle of a conversion returns the block to idle with `dac_code_o` = 0 and `hold_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| start_i | input | 1 | Start pulse, acted on only in idle |
| cmp_i | input | 1 | Comparator output, 1 when input is at or above DAC level |
| dac_code_o | output | WIDTH | Trial code for the ladder DAC |
| hold_o | output | 1 | Sample-and-hold control, 1 holds the input |
| done_o | output | 1 | One-cycle strobe when the result is updated |
| result_o | output | WIDTH | Last completed conversion result |

## Verification
The assertions assume that `start_i` is a clean synchronous level. They also assume that the comparator follows only the DAC code and the held input level, so it does not move during a bit step except through the code change. The bench models the comparator as an integer comparison between a fixed level and `dac_code_o`. The level is held constant for each whole conversion, and start is driven only at falling clock edges. Stray starts are injected only while a conversion is running, so the one-in-flight behaviour is exercised without ever violating these conditions.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [0:0] {
    SAR_IDLE  = 1'b0,
    SAR_TRIAL = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_settle_cnt.sv
module sar_settle_cnt #(
  parameter int SETTLE_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic settled_o
);
  localparam int CW = $clog2(SETTLE_CLKS + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CLKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign settled_o = (cnt_q == '0);
endmodule

// File: rtl/sar_bit_ctrl.sv
module sar_bit_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_s_i,
  input  logic             settled_i,
  output logic             load_o,
  output logic [WIDTH-1:0] code_o,
  output logic             hold_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state_q, state_d;
  logic [WIDTH-1:0] code_q, code_d, mask_q, mask_d, res_q, res_d;
  logic [WIDTH-1:0] decided;
  logic             hold_q, hold_d, done_q, done_d;
  logic             step_en, res_en;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    mask_d  = mask_q;
    hold_d  = hold_q;
    res_d   = res_q;
    done_d  = 1'b0;
    step_en = 1'b0;
    res_en  = 1'b0;
    load_o  = 1'b0;
    decided = cmp_s_i ? code_q : (code_q & ~mask_q);
    unique case (state_q)
      SAR_IDLE: begin
        if (start_i) begin
          state_d = SAR_TRIAL;
          code_d  = TOP_BIT;
          mask_d  = TOP_BIT;
          hold_d  = 1'b1;
          step_en = 1'b1;
          load_o  = 1'b1;
        end
      end
      SAR_TRIAL: begin
        if (settled_i) begin
          step_en = 1'b1;
          if (mask_q[0]) begin
            state_d = SAR_IDLE;
            code_d  = decided;
            hold_d  = 1'b0;
            done_d  = 1'b1;
            res_d   = decided;
            res_en  = 1'b1;
          end else begin
            mask_d = mask_q >> 1;
            code_d = decided | (mask_q >> 1);
            load_o = 1'b1;
          end
        end
      end
      default: state_d = SAR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SAR_IDLE;
      code_q  <= '0;
      mask_q  <= '0;
      hold_q  <= 1'b0;
    end else if (step_en) begin
      state_q <= state_d;
      code_q  <= code_d;
      mask_q  <= mask_d;
      hold_q  <= hold_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign code_o   = code_q;
  assign hold_o   = hold_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int WIDTH       = 8,
  parameter int SETTLE_CLKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             hold_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int SYNC_STAGES = 2;

  if (SETTLE_CLKS < SYNC_STAGES) begin : g_bad_settle
    initial $error("SETTLE_CLKS must cover the synchronizer delay");
  end
  if (WIDTH < 2) begin : g_bad_width
    initial $error("WIDTH must be at least 2");
  end

  logic cmp_s, settled, load;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  sar_settle_cnt #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .settled_o (settled)
  );

  sar_bit_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_s_i   (cmp_s),
    .settled_i (settled),
    .load_o    (load),
    .code_o    (dac_code_o),
    .hold_o    (hold_o),
    .done_o    (done_o),
    .result_o  (result_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             hold_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  AST_FIRST_TRIAL_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> dac_code_o == TOP_BIT); // R2
  AST_ONE_BIT_PER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(hold_o) && !$stable(dac_code_o)) |->
      $countones(dac_code_o ^ $past(dac_code_o)) <= 2); // R3
  AST_HOLD_ENDS_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> done_o); // R6
  AST_NO_HOLD_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hold_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o); // R7
  AST_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && start_i) |=> (hold_o || done_o)); // R8
endmodule

bind sar_seq_top sar_seq_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .dac_code_o (dac_code_o),
  .hold_o     (hold_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb_top;
  localparam int CLK_NS = 10;
  localparam int W      = 8;
  localparam int ST     = 2;
  localparam int LAT    = W * (ST + 1);
  localparam int NVEC   = 10;
  localparam int VEC_IN  [NVEC] = '{0, 255, 128, 127, 1, 170, 85, 300, 64, 200};
  localparam int VEC_EXP [NVEC] = '{0, 255, 128, 127, 1, 170, 85, 255, 64, 200};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         cmp;
  logic [W-1:0] dac, res;
  logic         hold, done;
  int           level;
  int           total = 0;
  int           bad   = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign cmp = (level >= int'(dac));

  sar_seq_top #(.WIDTH(W), .SETTLE_CLKS(ST)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .cmp_i (cmp),
    .dac_code_o (dac), .hold_o (hold), .done_o (done), .result_o (res)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one conversion; optionally pulses start mid-way (R8).
  task automatic convert(input int lvl, input int exp, input bit stray);
    int cyc = 0;
    int changes = 0;
    bit hold_ok = 1'b1;
    logic [W-1:0] prev;
    level = lvl;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check("R2 hold after start", int'(hold), 1);
    check("R2 first trial code", int'(dac), 1 << (W-1));
    prev = dac;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      start = (stray && cyc == 4) ? 1'b1 : 1'b0;
      if (done) break;
      if (!hold) hold_ok = 1'b0;
      if (dac != prev) changes++;
      prev = dac;
      if (cyc > 4 * LAT) break;
    end
    start = 1'b0;
    check("R5 latency", cyc, LAT);
    check("R6 hold through search", int'(hold_ok), 1);
    check("R6 hold low at done", int'(hold), 0);
    check("R4 code changes", changes, W - 1);
    check("R3 result", int'(res), exp);
    @(negedge clk);
    check("R7 done single cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R7 result held", int'(res), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; level = 0;
    repeat (3) @(negedge clk);
    check("R1 dac in reset", int'(dac), 0);
    check("R1 hold in reset", int'(hold), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 dac idle", int'(dac), 0);
    check("R1 hold idle", int'(hold), 0);
    check("R1 done idle", int'(done), 0);
    check("R1 result idle", int'(res), 0);

    for (int i = 0; i < NVEC; i++) convert(VEC_IN[i], VEC_EXP[i], 1'b0);

    // R8: stray start during a conversion
    convert(93, 93, 1'b1);
    convert(254, 254, 1'b1);

    // R9: reset in the middle of a conversion
    level = 150;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 dac after mid reset", int'(dac), 0);
    check("R9 hold after mid reset", int'(hold), 0);
    rst_n = 1'b1;
    repeat (LAT + 4) @(negedge clk);
    check("R9 stays idle", int'(hold), 0);
    check("R9 no done", int'(done), 0);
    convert(42, 42, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule